// File: doc/BRIEF.md
# Polled Eight-Level Interrupt Controller

This block gathers eight interrupt request lines and presents them to a processor that services interrupts by polling. It is programmed through a byte-wide register port with a single address bit. Address 0 carries command and status traffic and address 1 carries data and the mask.

After an initialization command and its follow-up words, software writes operational commands. These commands set the mask, retire in-service levels, move the lowest-priority level and select what a status read returns. A poll command turns the next status read into an acknowledge. That read returns the winning level and marks it in service.

The block keeps a request register, an in-service register and a mask register. Priority rotates around the eight levels, and an optional special mask mode is available. A request that is signalled on the interrupt output but withdrawn before the poll is reported as level 7 and is not put in service. Vector delivery and slave chaining are not modelled. The words that follow initialization are consumed, and their contents play no part in behaviour. Input 2 is an ordinary request line.

Top module: `poll_intc`

## Requirements
- R1: After reset the mask register reads 0x00, the request and in-service registers read 0x00, int_o is low, and IR0 has the highest priority.
- R2: A write to address 0 with bit 4 set starts initialization: it clears mask, in-service, special mask mode and poll, selects the request register for address-0 reads, and sets IR7 as lowest. The following address-1 writes are consumed in order as the vector word, then the cascade word (skipped when bit 1 was set), then the mode word (only when bit 0 was set). After that, address-1 writes load the mask and address-1 reads return it.
- R3: With bit 3 of the initialization byte clear, request bit n is set by a rising edge on req_i[n]. It is cleared when the input falls or when level n is acknowledged. An input already high at initialization is not latched until it rises again.
- R4: With bit 3 of the initialization byte set, request bit n follows req_i[n] and an acknowledge does not clear it.
- R5: Mask bit n set keeps IR n from winning a poll and from raising int_o; the request still shows in the request register.
- R6: int_o rises once an unmasked, unblocked request is pending and stays high until a poll read or a new initialization, even if the request goes away.
- R7: An address-0 write with bits 4:3 = 01 and bit 2 set arms a poll. The next address-0 read returns 0x80 | level of the winning request, sets that in-service bit, clears the request bit in edge mode, and disarms the poll.
- R8: An address-0 write with bits 7:5 = 110 makes level bits 2:0 the lowest; priority then runs from that level + 1 upward with wraparound (0xC2 gives 3,4,5,6,7,0,1,2).
- R9: An in-service level blocks its own and lower-priority requests. Specific end (bits 7:5 = 011) clears only the named level. Non-specific end (0x20) clears the highest-priority in-service bit.
- R10: Bits 7:5 = 111 clear the named in-service bit and make that level lowest. Bits 7:5 = 101 do the same for the highest-priority in-service level.
- R11: An address-0 write with bits 4:3 = 01 and bit 1 set selects address-0 reads: bit 0 = 1 gives the in-service register, 0 gives the request register. Bit 1 clear keeps the selection.
- R12: Bits 6:5 = 11 in that command enable special mask mode and 10 disable it. In that mode a masked in-service level does not block lower-priority requests.
- R13: A poll read with no eligible request returns 0x87 without touching the in-service register if int_o was high, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Interrupt request lines IR0..IR7 |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register address: 0 command/status, 1 data/mask |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after rd_i |
| int_o | output | 1 | Interrupt pending indication |

## Verification
The hardest case to reach is the spurious report. It needs int_o already latched high, then the request withdrawn before the poll, so the poll finds nothing eligible. The stimulus raises IR1, waits until int_o is up, and drops IR1. It then confirms the request register reads zero, arms a poll and expects 0x87 with the in-service register still empty. The special-mask case is reached in a similar staged way: a level is put in service, a lower request is shown to be blocked, and then the level is masked and the mode entered before a poll.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NUM_LVL = 8;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);

  typedef enum logic [1:0] {
    ST_RUN,
    ST_VEC,
    ST_CASC,
    ST_MODE
  } init_st_e;

  localparam logic [2:0] OP_EOI_ANY = 3'b001;
  localparam logic [2:0] OP_EOI_SPC = 3'b011;
  localparam logic [2:0] OP_ROT_ANY = 3'b101;
  localparam logic [2:0] OP_SET_LOW = 3'b110;
  localparam logic [2:0] OP_ROT_SPC = 3'b111;
endpackage

// File: rtl/intc_irr.sv
module intc_irr #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         level_i,
  input  logic         clr_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q, irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else if (clr_i) begin
      prev_q <= '1;  // held-high inputs must rise again
      irr_q  <= '0;
    end else begin
      prev_q <= req_i;
      if (level_i) irr_q <= req_i;
      else         irr_q <= (irr_q | (req_i & ~prev_q)) & req_i & ~ack_i;
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/intc_resolve.sv
module intc_resolve
  import intc_pkg::*;
(
  input  logic [NUM_LVL-1:0] irr_i,
  input  logic [NUM_LVL-1:0] imr_i,
  input  logic [NUM_LVL-1:0] isr_i,
  input  logic               smm_i,
  input  logic [LVL_W-1:0]   lowest_i,
  output logic               req_vld_o,
  output logic [LVL_W-1:0]   req_lvl_o,
  output logic               isr_vld_o,
  output logic [LVL_W-1:0]   isr_lvl_o
);
  always_comb begin
    logic [LVL_W-1:0] idx;
    logic             stop;
    req_vld_o = 1'b0;
    req_lvl_o = '0;
    isr_vld_o = 1'b0;
    isr_lvl_o = '0;
    stop      = 1'b0;
    for (int i = 0; i < NUM_LVL; i++) begin
      idx = lowest_i + LVL_W'(i + 1);
      if (!stop) begin
        if (isr_i[idx] && !(smm_i && imr_i[idx])) begin
          stop = 1'b1;
        end else if (irr_i[idx] && !imr_i[idx]) begin
          req_vld_o = 1'b1;
          req_lvl_o = idx;
          stop      = 1'b1;
        end
      end
      if (!isr_vld_o && isr_i[idx]) begin
        isr_vld_o = 1'b1;
        isr_lvl_o = idx;
      end
    end
  end
endmodule

// File: rtl/poll_intc.sv
module poll_intc
  import intc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] req_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       int_o
);
  init_st_e           st_q;
  logic               need_mode_q, single_q, level_q;
  logic [NUM_LVL-1:0] imr_q, isr_q, irr;
  logic [LVL_W-1:0]   lowest_q;
  logic               smm_q, rd_isr_q, poll_q, int_q;
  logic [7:0]         rdata_q;

  logic               req_vld, isr_vld;
  logic [LVL_W-1:0]   req_lvl, isr_lvl;

  logic wr0, wr1, rd0, rd1, icw1, ocw2, ocw3, poll_ack;
  logic [NUM_LVL-1:0] ack_vec, eoi_vec;
  logic [2:0]         op;
  logic [7:0]         status;

  assign wr0  = wr_i && !addr_i;
  assign wr1  = wr_i &&  addr_i;
  assign rd0  = rd_i && !addr_i;
  assign rd1  = rd_i &&  addr_i;
  assign icw1 = wr0 && wdata_i[4];
  assign ocw2 = wr0 && !wdata_i[4] && !wdata_i[3] && (st_q == ST_RUN);
  assign ocw3 = wr0 && !wdata_i[4] &&  wdata_i[3] && (st_q == ST_RUN);
  assign op   = wdata_i[7:5];

  assign poll_ack = rd0 && poll_q && req_vld;
  assign ack_vec  = poll_ack ? (NUM_LVL'(1) << req_lvl) : '0;

  always_comb begin
    eoi_vec = '0;
    if (ocw2) begin
      unique case (op)
        OP_EOI_ANY, OP_ROT_ANY: if (isr_vld) eoi_vec = NUM_LVL'(1) << isr_lvl;
        OP_EOI_SPC, OP_ROT_SPC: eoi_vec = NUM_LVL'(1) << wdata_i[2:0];
        default: eoi_vec = '0;
      endcase
    end
  end

  assign status = req_vld ? {1'b1, 4'b0000, req_lvl} :
                  int_q   ? 8'h87 : 8'h00;

  intc_irr #(.N(NUM_LVL)) u_irr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .level_i(level_q),
    .clr_i  (icw1),
    .ack_i  (ack_vec),
    .irr_o  (irr)
  );

  intc_resolve u_res (
    .irr_i    (irr),
    .imr_i    (imr_q),
    .isr_i    (isr_q),
    .smm_i    (smm_q),
    .lowest_i (lowest_q),
    .req_vld_o(req_vld),
    .req_lvl_o(req_lvl),
    .isr_vld_o(isr_vld),
    .isr_lvl_o(isr_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_RUN;
      need_mode_q <= 1'b0;
      single_q    <= 1'b0;
      level_q     <= 1'b0;
      imr_q       <= '0;
      isr_q       <= '0;
      lowest_q    <= LVL_W'(NUM_LVL - 1);
      smm_q       <= 1'b0;
      rd_isr_q    <= 1'b0;
      poll_q      <= 1'b0;
      int_q       <= 1'b0;
      rdata_q     <= '0;
    end else if (icw1) begin
      st_q        <= ST_VEC;
      need_mode_q <= wdata_i[0];
      single_q    <= wdata_i[1];
      level_q     <= wdata_i[3];
      imr_q       <= '0;
      isr_q       <= '0;
      lowest_q    <= LVL_W'(NUM_LVL - 1);
      smm_q       <= 1'b0;
      rd_isr_q    <= 1'b0;
      poll_q      <= 1'b0;
      int_q       <= 1'b0;
    end else begin
      if (wr1) begin
        unique case (st_q)
          ST_VEC:  st_q <= single_q ? (need_mode_q ? ST_MODE : ST_RUN) : ST_CASC;
          ST_CASC: st_q <= need_mode_q ? ST_MODE : ST_RUN;
          ST_MODE: st_q <= ST_RUN;
          default: imr_q <= wdata_i;
        endcase
      end
      isr_q <= (isr_q & ~eoi_vec) | ack_vec;
      if (ocw2) begin
        if (op == OP_SET_LOW || op == OP_ROT_SPC) lowest_q <= wdata_i[2:0];
        else if (op == OP_ROT_ANY && isr_vld)     lowest_q <= isr_lvl;
      end
      if (ocw3) begin
        if (wdata_i[6:5] == 2'b11)      smm_q <= 1'b1;
        else if (wdata_i[6:5] == 2'b10) smm_q <= 1'b0;
        if (wdata_i[1]) rd_isr_q <= wdata_i[0];
        poll_q <= wdata_i[2];
      end else if (rd0) begin
        poll_q <= 1'b0;
      end
      if (rd0 && poll_q) int_q <= 1'b0;
      else               int_q <= int_q | req_vld;
      if (rd0)      rdata_q <= poll_q ? status : (rd_isr_q ? isr_q : irr);
      else if (rd1) rdata_q <= imr_q;
    end
  end

  assign rdata_o = rdata_q;
  assign int_o   = int_q;
endmodule

// File: rtl/poll_intc_chk.sv
module poll_intc_chk
  import intc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rd_i,
  input logic               wr_i,
  input logic               addr_i,
  input logic [7:0]         wdata_i,
  input logic [7:0]         rdata_o,
  input logic               int_o,
  input logic [NUM_LVL-1:0] isr_q,
  input logic [NUM_LVL-1:0] imr_q,
  input logic               poll_q,
  input logic               smm_q,
  input logic               req_vld,
  input logic [LVL_W-1:0]   req_lvl
);
  logic poll_rd;
  assign poll_rd = rd_i && !addr_i && poll_q;

  assert_init_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[4]) |=> (isr_q == '0 && imr_q == '0 && !int_o));

  assert_mask_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld |-> !imr_q[req_lvl]);

  assert_int_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && !poll_rd && !(wr_i && !addr_i && wdata_i[4])) |=> int_o);

  assert_poll_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd && req_vld) |=> (rdata_o[7] && isr_q[rdata_o[2:0]] && !poll_q));

  assert_isr_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld && !smm_q) |-> !isr_q[req_lvl]);

  assert_spurious_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd && !req_vld) |=> (isr_q == $past(isr_q) && rdata_o[6:3] == 4'b0000));
endmodule

bind poll_intc poll_intc_chk u_chk (.*);

// File: tb/poll_intc_bench.sv
`timescale 1ns/1ps
module poll_intc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  poll_intc u_poll_intc (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .int_o(irq)
  );

  always @(posedge clk) rd_seen <= rd;

  // monitor: compare each read result against the queued expectation
  initial forever begin
    @(negedge clk);
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read act=%02h exp=none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s act=%02h exp=%02h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic poll(input logic [7:0] e, input string t);
    wr_reg(1'b0, 8'h0C);
    rd_reg(1'b0, e, t);
  endtask

  task automatic set_req(input logic [7:0] v);
    @(negedge clk); req = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_int(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(1'b1, 8'h00, "R1 mask after reset");
    rd_reg(1'b0, 8'h00, "R1 request reg after reset");
    chk_int(1'b0, "R1 int_o after reset");
    // R2 initialization words are consumed
    wr_reg(1'b0, 8'h11);
    wr_reg(1'b1, 8'h00);
    rd_reg(1'b1, 8'h00, "R2 mask untouched by vector word");
    wr_reg(1'b1, 8'h04);
    wr_reg(1'b1, 8'h01);
    rd_reg(1'b1, 8'h00, "R2 mask untouched by cascade/mode words");
    wr_reg(1'b1, 8'hFF);
    rd_reg(1'b1, 8'hFF, "R2 mask load after init");
    // R5 masked request
    set_req(8'h08);
    rd_reg(1'b0, 8'h08, "R5 masked request visible");
    chk_int(1'b0, "R5 masked request no int");
    poll(8'h00, "R13 empty poll without int");
    wr_reg(1'b1, 8'h00);
    repeat (3) @(negedge clk);
    chk_int(1'b1, "R6 int after unmask");
    set_req(8'h28);
    poll(8'h83, "R7 poll returns IR3");
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, 8'h08, "R11 read in-service select");
    wr_reg(1'b0, 8'h0A);
    rd_reg(1'b0, 8'h20, "R3 ack clears edge request");
    chk_int(1'b0, "R9 lower request blocked by in-service");
    wr_reg(1'b0, 8'h63);
    repeat (3) @(negedge clk);
    chk_int(1'b1, "R9 int after specific end");
    poll(8'h85, "R9 lower level after specific end");
    wr_reg(1'b0, 8'h20);
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, 8'h00, "R9 non-specific end clears");
    set_req(8'h00);
    // R13 spurious
    set_req(8'h02);
    chk_int(1'b1, "R6 int for IR1");
    set_req(8'h00);
    wr_reg(1'b0, 8'h0A);
    rd_reg(1'b0, 8'h00, "R3 request cleared on falling input");
    chk_int(1'b1, "R6 int held after withdrawal");
    poll(8'h87, "R13 spurious report");
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, 8'h00, "R13 spurious leaves in-service empty");
    chk_int(1'b0, "R6 int cleared by poll");
    // R8 priority rotation to 3..7,0,1,2
    wr_reg(1'b0, 8'hC2);
    set_req(8'h16);
    poll(8'h84, "R8 IR4 first");
    wr_reg(1'b0, 8'h64);
    poll(8'h81, "R8 IR1 second");
    wr_reg(1'b0, 8'h61);
    poll(8'h82, "R8 IR2 last");
    wr_reg(1'b0, 8'h62);
    poll(8'h00, "R13 nothing left");
    set_req(8'h00);
    // R10 rotate on specific end
    wr_reg(1'b0, 8'hC7);
    set_req(8'h03);
    poll(8'h80, "R10 IR0 first before rotation");
    wr_reg(1'b0, 8'hE0);
    set_req(8'h02);
    set_req(8'h03);
    poll(8'h81, "R10 IR1 above IR0 after rotation");
    wr_reg(1'b0, 8'h61);
    poll(8'h80, "R10 IR0 after IR1");
    wr_reg(1'b0, 8'h60);
    set_req(8'h00);
    // R12 special mask mode
    wr_reg(1'b0, 8'hC7);
    set_req(8'h01);
    poll(8'h80, "R12 IR0 in service");
    set_req(8'h11);
    poll(8'h00, "R9 IR4 blocked by IR0");
    wr_reg(1'b1, 8'h01);
    wr_reg(1'b0, 8'h68);
    poll(8'h84, "R12 masked in-service does not block");
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, 8'h11, "R12 both levels in service");
    wr_reg(1'b0, 8'h48);
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, 8'h10, "R9 non-specific end clears highest");
    wr_reg(1'b0, 8'h64);
    wr_reg(1'b1, 8'h00);
    set_req(8'h00);
    // R4 level mode
    wr_reg(1'b1, 8'h5A);
    wr_reg(1'b0, 8'h19);
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b1, 8'h04);
    wr_reg(1'b1, 8'h01);
    rd_reg(1'b1, 8'h00, "R2 init clears mask");
    set_req(8'h40);
    poll(8'h86, "R4 level poll IR6");
    rd_reg(1'b0, 8'h40, "R4 level request kept after ack");
    wr_reg(1'b0, 8'h66);
    set_req(8'h00);
    rd_reg(1'b0, 8'h00, "R4 level request follows input");
    // R3 re-arm after init, R2 single mode skips cascade word
    set_req(8'h04);
    wr_reg(1'b0, 8'h13);
    wr_reg(1'b1, 8'h20);
    wr_reg(1'b1, 8'h01);
    wr_reg(1'b1, 8'h80);
    rd_reg(1'b1, 8'h80, "R2 single mode skips cascade");
    rd_reg(1'b0, 8'h00, "R3 held input not latched after init");
    set_req(8'h00);
    set_req(8'h04);
    rd_reg(1'b0, 8'h04, "R3 latched on new rising edge");
    chk_int(1'b1, "R6 int for IR2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule